// File: doc/BRIEF.md
# Data Memory with Mapped Core Registers

This block is the data-side memory of a small 16-bit accumulator processor. It stores 512 words of 16 bits, addressed by word, in the lower half of a 10-bit address space. The upper half opens a register window. In that window, software can read the working register, read and write the carry and zero flags, and use a two-register indirect access unit. The indirect unit is a 9-bit pointer and a value port that reads or writes the RAM word the pointer selects.

The processor core drives one address, its write data and a write strobe each cycle. Reads return combinationally from the address. Writes commit on the rising clock edge. The flag registers live here: the ALU updates them through its own load strobes, and a store through the memory window overrides the ALU in the same cycle.

Software indexes an array in three steps. It loads a base address into the pointer, adds an index to the pointer in place through the memory window, and then reads or writes the value port.

Top module: `dmem_core`

## Requirements
- R1: Addresses 0x000 to 0x1FF hold independent 16-bit RAM words. A read returns the word combinationally, and a write with `mem_we` high commits on the rising clock edge.
- R2: Address 0x200 reads the value on `wreg_in`. A write to 0x200 changes no RAM word and no register.
- R3: Address 0x201 reads the carry flag in bit 0, with bits 15:1 read as 0. A write there loads `wr_data[0]` into the carry flag, which drives `carry_q`, and the upper bits are dropped.
- R4: Address 0x202 behaves the same way for the zero flag, which drives `zero_q`.
- R5: When no memory write targets a flag, the flag loads its ALU value on a clock edge where that flag's ALU load strobe is high. Otherwise it holds.
- R6: A memory write to a flag and the ALU load of that flag in the same cycle leave the memory write data in the flag.
- R7: Address 0x204 is a 9-bit pointer. A write keeps `wr_data[8:0]`, and a read returns the pointer with bits 15:9 as 0.
- R8: Address 0x203 reads the RAM word at the pointer, and a write to 0x203 stores `wr_data` into that RAM word.
- R9: Reading the pointer, adding an index and writing the sum back to 0x204 makes 0x203 access the word at base plus index.
- R10: Addresses 0x205 to 0x3FF read as 0, and writes to them change no RAM word.
- R11: After reset, the carry flag, the zero flag and the pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | input | 10 | Word address |
| wr_data | input | 16 | Write data |
| mem_we | input | 1 | Write enable for the addressed word |
| wreg_in | input | 16 | Current working register value |
| alu_c_ld | input | 1 | ALU load strobe for carry |
| alu_c | input | 1 | Carry value from the ALU |
| alu_z_ld | input | 1 | ALU load strobe for zero |
| alu_z | input | 1 | Zero value from the ALU |
| rd_data | output | 16 | Combinational read data |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |

## Verification
The assertions assume that `mem_addr`, `mem_we` and the ALU strobes are driven to known values whenever the internal reset is released. A write is taken to be a single-cycle strobe, sampled at the rising edge. The bench drives every input on the falling edge, holds the address steady for each read check, and gives all inputs defined values before it releases reset. RAM words are written before they are read, because the storage itself has no reset.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  // Offsets inside the register window (address bit 9 set)
  localparam int unsigned OFF_WREG  = 0;
  localparam int unsigned OFF_CARRY = 1;
  localparam int unsigned OFF_ZERO  = 2;
  localparam int unsigned OFF_VAL   = 3;
  localparam int unsigned OFF_PTR   = 4;

  typedef enum logic [2:0] {
    SEL_RAM, SEL_WREG, SEL_CARRY, SEL_ZERO, SEL_VAL, SEL_PTR, SEL_NONE
  } dmem_sel_e;
endpackage

// File: rtl/dmem_rst_sync.sv
module dmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/dmem_flag.sv
module dmem_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_ld,
  input  logic mem_d,
  input  logic alu_ld,
  input  logic alu_d,
  output logic q
);
  logic d_next;

  always_comb begin
    d_next = q;
    if (mem_ld)      d_next = mem_d;
    else if (alu_ld) d_next = alu_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_next;
  end

  assert_mem_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ld |=> q == $past(mem_d));
  assert_alu_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld && alu_ld) |=> q == $past(alu_d));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld && !alu_ld) |=> $stable(q));
endmodule

// File: rtl/dmem_ptr.sv
module dmem_ptr #(
  parameter int DATA_W = 16,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     ptr
);
  logic [AW-1:0] ptr_next;

  always_comb begin
    ptr_next = ptr;
    if (ld) ptr_next = wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end

  assert_ptr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ptr == $past(wdata[AW-1:0]));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(ptr));
endmodule

// File: rtl/dmem_core.sv
module dmem_core #(
  parameter int DATA_W = 16,
  parameter int RAM_AW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RAM_AW:0]     mem_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   wreg_in,
  input  logic                alu_c_ld,
  input  logic                alu_c,
  input  logic                alu_z_ld,
  input  logic                alu_z,
  output logic [DATA_W-1:0]   rd_data,
  output logic                carry_q,
  output logic                zero_q
);
  import dmem_pkg::*;

  localparam int ADDR_W = RAM_AW + 1;
  localparam int NFLAG  = 2;

  logic              rst_n_i;
  dmem_sel_e         sel;
  logic [RAM_AW-1:0] win_off;
  logic [RAM_AW-1:0] ptr;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rdata;
  logic [NFLAG-1:0]  flag_mem_ld, flag_alu_ld, flag_alu_d, flag_q;

  dmem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  // Address decode
  assign win_off = mem_addr[RAM_AW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (!mem_addr[ADDR_W-1]) sel = SEL_RAM;
    else begin
      case (win_off)
        RAM_AW'(OFF_WREG):  sel = SEL_WREG;
        RAM_AW'(OFF_CARRY): sel = SEL_CARRY;
        RAM_AW'(OFF_ZERO):  sel = SEL_ZERO;
        RAM_AW'(OFF_VAL):   sel = SEL_VAL;
        RAM_AW'(OFF_PTR):   sel = SEL_PTR;
        default:            sel = SEL_NONE;
      endcase
    end
  end

  // One RAM port, address taken from the bus or from the pointer
  assign ram_addr = (sel == SEL_VAL) ? ptr : win_off;
  assign ram_we   = mem_we && (sel == SEL_RAM || sel == SEL_VAL);

  dmem_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(wr_data), .rdata(ram_rdata)
  );

  dmem_ptr #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ptr (
    .clk(clk), .rst_n(rst_n_i), .ld(mem_we && sel == SEL_PTR),
    .wdata(wr_data), .ptr(ptr)
  );

  // Flags: index 0 carry, index 1 zero
  assign flag_mem_ld = {mem_we && sel == SEL_ZERO, mem_we && sel == SEL_CARRY};
  assign flag_alu_ld = {alu_z_ld, alu_c_ld};
  assign flag_alu_d  = {alu_z, alu_c};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    dmem_flag u_flag (
      .clk(clk), .rst_n(rst_n_i),
      .mem_ld(flag_mem_ld[i]), .mem_d(wr_data[0]),
      .alu_ld(flag_alu_ld[i]), .alu_d(flag_alu_d[i]),
      .q(flag_q[i])
    );
  end

  assign carry_q = flag_q[0];
  assign zero_q  = flag_q[1];

  // Read mux
  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_RAM, SEL_VAL: rd_data = ram_rdata;
      SEL_WREG:         rd_data = wreg_in;
      SEL_CARRY:        rd_data = DATA_W'(carry_q);
      SEL_ZERO:         rd_data = DATA_W'(zero_q);
      SEL_PTR:          rd_data = DATA_W'(ptr);
      default:          rd_data = '0;
    endcase
  end

  assert_wreg_read_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_addr == ADDR_W'(32'h200)) |-> rd_data == wreg_in);
  assert_flag_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_addr == ADDR_W'(32'h201) || mem_addr == ADDR_W'(32'h202))
      |-> rd_data[DATA_W-1:1] == '0);
  assert_ptr_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_addr == ADDR_W'(32'h204)) |-> rd_data[DATA_W-1:RAM_AW] == '0);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_addr > ADDR_W'(32'h204)) |-> rd_data == '0);
  assert_unmapped_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_addr > ADDR_W'(32'h204) || mem_addr == ADDR_W'(32'h200)) |-> !ram_we);
endmodule

// File: tb/sim_dmem_core.sv
module sim_dmem_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  mem_addr;
  logic [15:0] wr_data, wreg_in, rd_data;
  logic        mem_we, alu_c_ld, alu_c, alu_z_ld, alu_z, carry_q, zero_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dmem_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .wr_data(wr_data),
    .mem_we(mem_we), .wreg_in(wreg_in), .alu_c_ld(alu_c_ld), .alu_c(alu_c),
    .alu_z_ld(alu_z_ld), .alu_z(alu_z), .rd_data(rd_data),
    .carry_q(carry_q), .zero_q(zero_q)
  );

  // Vector: {is_read, addr[9:0], data[15:0]}; is_read checks data, else writes it
  localparam int NV = 26;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 10'h000, 16'h1234}, {1'b0, 10'h1FF, 16'hBEEF},
    {1'b0, 10'h005, 16'h0055}, {1'b1, 10'h000, 16'h1234},
    {1'b1, 10'h1FF, 16'hBEEF}, {1'b0, 10'h200, 16'hFFFF},
    {1'b1, 10'h200, 16'hA5C3}, {1'b1, 10'h000, 16'h1234},
    {1'b0, 10'h201, 16'hFFFF}, {1'b1, 10'h201, 16'h0001},
    {1'b0, 10'h201, 16'hFFFE}, {1'b1, 10'h201, 16'h0000},
    {1'b0, 10'h202, 16'h0003}, {1'b1, 10'h202, 16'h0001},
    {1'b0, 10'h204, 16'hFE10}, {1'b1, 10'h204, 16'h0010},
    {1'b0, 10'h203, 16'hCAFE}, {1'b1, 10'h010, 16'hCAFE},
    {1'b1, 10'h203, 16'hCAFE}, {1'b0, 10'h205, 16'h7777},
    {1'b1, 10'h205, 16'h0000}, {1'b0, 10'h3FF, 16'h1111},
    {1'b1, 10'h3FF, 16'h0000}, {1'b1, 10'h005, 16'h0055},
    {1'b1, 10'h1FF, 16'hBEEF}, {1'b1, 10'h204, 16'h0010}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_addr = a; wr_data = d; mem_we = 1'b1;
    @(posedge clk);
    #1 mem_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    mem_we = 1'b0; mem_addr = a;
    #1 d = rd_data;
  endtask

  function automatic string req_of(input logic [9:0] a);
    if (a < 10'h200)       return "R1";
    else if (a == 10'h200) return "R2";
    else if (a == 10'h201) return "R3";
    else if (a == 10'h202) return "R4";
    else if (a == 10'h203) return "R8";
    else if (a == 10'h204) return "R7";
    else                   return "R10";
  endfunction

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; mem_addr = '0; wr_data = '0; mem_we = 1'b0;
    wreg_in = 16'hA5C3; alu_c_ld = 1'b0; alu_c = 1'b0; alu_z_ld = 1'b0; alu_z = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 reset state
    rd(10'h201, r); check("R11 carry", r, 16'h0000);
    rd(10'h202, r); check("R11 zero", r, 16'h0000);
    rd(10'h204, r); check("R11 ptr", r, 16'h0000);
    check("R11 carry_q", {15'd0, carry_q}, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        rd(VEC[i][25:16], r);
        check(req_of(VEC[i][25:16]), r, VEC[i][15:0]);
      end else begin
        wr(VEC[i][25:16], VEC[i][15:0]);
      end
    end
    check("R3 carry_q", {15'd0, carry_q}, 16'h0000);
    check("R4 zero_q", {15'd0, zero_q}, 16'h0001);

    // R5 ALU loads flags
    @(negedge clk);
    alu_c_ld = 1'b1; alu_c = 1'b1; alu_z_ld = 1'b1; alu_z = 1'b0;
    @(posedge clk); #1 alu_c_ld = 1'b0; alu_z_ld = 1'b0;
    check("R5 carry_q", {15'd0, carry_q}, 16'h0001);
    check("R5 zero_q", {15'd0, zero_q}, 16'h0000);
    @(posedge clk); #1;
    check("R5 hold", {15'd0, carry_q}, 16'h0001);

    // R6 memory write beats ALU in same cycle
    @(negedge clk);
    alu_c_ld = 1'b1; alu_c = 1'b1;
    mem_addr = 10'h201; wr_data = 16'h0000; mem_we = 1'b1;
    @(posedge clk); #1 alu_c_ld = 1'b0; mem_we = 1'b0;
    check("R6 carry", {15'd0, carry_q}, 16'h0000);
    @(negedge clk);
    alu_z_ld = 1'b1; alu_z = 1'b0;
    mem_addr = 10'h202; wr_data = 16'h0001; mem_we = 1'b1;
    @(posedge clk); #1 alu_z_ld = 1'b0; mem_we = 1'b0;
    check("R6 zero", {15'd0, zero_q}, 16'h0001);

    // R9 array indexing: base 0x020, index 3
    wr(10'h023, 16'h4242);
    wr(10'h204, 16'h0020);
    rd(10'h204, r);
    wr(10'h204, r + 16'(wreg_in[1:0]));
    rd(10'h203, r); check("R9 read", r, 16'h4242);
    wr(10'h203, 16'h5151);
    rd(10'h023, r); check("R9 write", r, 16'h5151);

    // R7 upper bits dropped on pointer write
    wr(10'h204, 16'hFFFF);
    rd(10'h204, r); check("R7 mask", r, 16'h01FF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule